// File: doc/BRIEF.md
# Receive Frame Buffer with Size-Class Selection

This block sits between a MAC-side receive byte stream and a DMA engine. It stores each incoming Ethernet frame whole in a 2048-byte circular buffer and releases nothing until the frame's last byte has arrived and its outcome is known. The outcome comes in as flags on the final byte: a checksum error, a fragment error, an illegal length, and whether the destination address passed filtering. A frame that fails any of these checks, or that runs out of room, is removed as a unit by moving the write pointer back to the last committed position. A frame that passes is committed by moving the committed pointer forward.

For every frame that ends, a 16-bit status word is pulsed out for one cycle, which can be used as an interrupt source. Each committed frame also gets a descriptor: its byte count, its status word and one of four buffer-size classes. The size class comes from comparing the byte count with three programmable thresholds in ascending order. Descriptors wait in a small side queue, so the DMA side learns a frame's length and class before it fetches any data. It then pulls the bytes out one per `rd_en` cycle.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset, `desc_valid`, `stat_valid` and `rd_valid` are all 0.
- R2: A frame that ends with no error flag and with `rx_addr_hit` high is committed. One cycle after its end-of-frame byte, `stat_valid` pulses with status bit 0 (accepted) set, and `desc_valid` is high with `desc_len` equal to the frame's byte count.
- R3: A frame that ends with `rx_crc_bad`, `rx_frag_err` or `rx_len_err` set is dropped. Its status pulse has bit 0 clear and bit 1, 2 or 3 set respectively. No descriptor appears, and frames committed later read back intact.
- R4: A frame that ends with `rx_addr_hit` low is dropped, and its status has bit 4 set and bit 0 clear.
- R5: The size class is 0 if length <= `thr_a`, else 1 if length <= `thr_b`, else 2 if length <= `thr_c`, else 3. It appears on `desc_class` and in status bits 7:6.
- R6: A frame that does not fit in the free space is truncated and dropped, with status bit 5 set and bit 0 clear. Frames committed earlier are not disturbed. Occupancy never exceeds DEPTH.
- R7: Bytes with `rx_valid` high outside a frame are ignored. A start-of-frame that arrives inside an unfinished frame silently discards the partial frame, with no status pulse, and starts a new one.
- R8: While a frame is still arriving, no descriptor for it is shown. `rd_en` with no descriptor pending produces no `rd_valid`.
- R9: Each accepted `rd_en` returns the next byte of the head frame on `rd_data` one cycle later, with `rd_valid` high. `rd_last` marks the final byte, after which the descriptor is removed.
- R10: A frame that ends while the descriptor queue is full is dropped, with status bit 5 set and bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame; error and filter flags are sampled with it |
| rx_data | input | DW | Receive byte |
| rx_crc_bad | input | 1 | Checksum failed |
| rx_frag_err | input | 1 | Fragment error |
| rx_len_err | input | 1 | Illegal frame length |
| rx_addr_hit | input | 1 | Destination address accepted by the filter |
| thr_a | input | LW | Upper bound of size class 0 |
| thr_b | input | LW | Upper bound of size class 1 |
| thr_c | input | LW | Upper bound of size class 2 |
| stat_valid | output | 1 | One-cycle pulse per ended frame |
| stat_word | output | 16 | Status: 0 accepted, 1 crc, 2 fragment, 3 length, 4 address miss, 5 overflow, 7:6 class |
| desc_valid | output | 1 | A committed frame is waiting |
| desc_len | output | LW | Byte count of the head frame |
| desc_class | output | 2 | Size class of the head frame |
| desc_status | output | 16 | Status word of the head frame |
| rd_en | input | 1 | Request next byte of the head frame |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_data | output | DW | Frame byte |
| rd_last | output | 1 | Final byte of the frame |

## Verification
If a pointer is left in the wrong place after a rollback, the next committed frame shows it: its bytes come back shifted or mixed with those of the rejected frame, and its length is wrong as soon as its descriptor appears. A wrong free-space count shows up on the first frame that nearly fills the buffer. That frame either gets the overflow bit when it should not, or corrupts an earlier committed frame that is read back afterwards. A wrong descriptor-queue count or read counter shows within one frame, as a missing or early `rd_last` or a descriptor that never clears.

// File: rtl/rx_fb_pkg.sv
package rx_fb_pkg;
  // status word bit positions
  localparam int ST_OK   = 0;
  localparam int ST_CRC  = 1;
  localparam int ST_FRAG = 2;
  localparam int ST_LEN  = 3;
  localparam int ST_ADDR = 4;
  localparam int ST_OVF  = 5;
  localparam int ST_CLS  = 6;
  localparam int ST_W    = 16;

  typedef logic [1:0] size_cls_t;
endpackage

// File: rtl/rx_fb_ram.sv
module rx_fb_ram #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  localparam int N = 1 << AW;
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/rx_fb_classify.sv
module rx_fb_classify import rx_fb_pkg::*; #(
  parameter int LW = 12
) (
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] t0,
  input  logic [LW-1:0] t1,
  input  logic [LW-1:0] t2,
  output size_cls_t     cls
);
  always_comb begin
    if (len <= t0)      cls = 2'd0;
    else if (len <= t1) cls = 2'd1;
    else if (len <= t2) cls = 2'd2;
    else                cls = 2'd3;
  end
endmodule

// File: rtl/rx_fb_descq.sv
module rx_fb_descq #(
  parameter int W     = 28,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int IW = $clog2(DEPTH);
  logic [W-1:0]  slot [DEPTH];
  logic [IW-1:0] wi, ri;
  logic [IW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (IW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slot[ri];

  always_ff @(posedge clk) begin
    if (do_push) slot[wi] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wi  <= '0;
      ri  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wi <= wi + 1'b1;
      if (do_pop)  ri <= ri + 1'b1;
      cnt <= cnt + (IW+1)'(do_push) - (IW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf import rx_fb_pkg::*; #(
  parameter int DEPTH    = 2048,
  parameter int DQ_DEPTH = 8,
  parameter int DW       = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1,
  localparam int LW      = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_crc_bad,
  input  logic          rx_frag_err,
  input  logic          rx_len_err,
  input  logic          rx_addr_hit,
  input  logic [LW-1:0] thr_a,
  input  logic [LW-1:0] thr_b,
  input  logic [LW-1:0] thr_c,
  output logic          stat_valid,
  output logic [15:0]   stat_word,
  output logic          desc_valid,
  output logic [LW-1:0] desc_len,
  output logic [1:0]    desc_class,
  output logic [15:0]   desc_status,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last
);
  localparam int QW = ST_W + LW;

  // write side state
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
  logic          in_frame, ovf_r;

  logic          beat_ok, eof_beat, room, store, ovf_in, ovf_next, accept;
  logic [PW-1:0] eff_wp, occ;
  logic [LW-1:0] frame_len;
  size_cls_t     cls;
  logic [ST_W-1:0] st_next;

  // read side state
  logic [LW-1:0] rd_cnt;
  logic          rd_go, last_now;
  logic          dq_push, dq_pop, dq_empty, dq_full;
  logic [QW-1:0] dq_din, dq_dout;

  always_comb begin
    beat_ok   = rx_valid && (rx_sof || in_frame);
    eof_beat  = beat_ok && rx_eof;
    eff_wp    = rx_sof ? cm_ptr : wr_ptr;
    occ       = eff_wp - rd_ptr;
    room      = (occ != PW'(DEPTH));
    ovf_in    = rx_sof ? 1'b0 : ovf_r;
    store     = beat_ok && !ovf_in && room;
    ovf_next  = ovf_in || !room;
    frame_len = LW'(eff_wp - cm_ptr) + LW'(1);
    accept    = !rx_crc_bad && !rx_frag_err && !rx_len_err && rx_addr_hit
                && !ovf_next && !dq_full;
    st_next                 = '0;
    st_next[ST_OK]          = accept;
    st_next[ST_CRC]         = rx_crc_bad;
    st_next[ST_FRAG]        = rx_frag_err;
    st_next[ST_LEN]         = rx_len_err;
    st_next[ST_ADDR]        = !rx_addr_hit;
    st_next[ST_OVF]         = ovf_next || dq_full;
    st_next[ST_CLS+1:ST_CLS] = cls;
    dq_push   = eof_beat && accept;
    dq_din    = {st_next, frame_len};
  end

  rx_fb_classify #(.LW(LW)) u_cls (
    .len (frame_len),
    .t0  (thr_a),
    .t1  (thr_b),
    .t2  (thr_c),
    .cls (cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      cm_ptr     <= '0;
      in_frame   <= 1'b0;
      ovf_r      <= 1'b0;
      stat_valid <= 1'b0;
      stat_word  <= '0;
    end else begin
      stat_valid <= eof_beat;
      if (eof_beat) stat_word <= st_next;
      if (beat_ok) begin
        in_frame <= !rx_eof;
        ovf_r    <= rx_eof ? 1'b0 : ovf_next;
        if (rx_eof) begin
          if (accept) begin
            cm_ptr <= eff_wp + PW'(1);
            wr_ptr <= eff_wp + PW'(1);
          end else begin
            wr_ptr <= cm_ptr;
          end
        end else begin
          wr_ptr <= eff_wp + PW'(store);
        end
      end
    end
  end

  rx_fb_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk (clk),
    .we  (store),
    .wa  (eff_wp[AW-1:0]),
    .wd  (rx_data),
    .re  (rd_go),
    .ra  (rd_ptr[AW-1:0]),
    .rq  (rd_data)
  );

  rx_fb_descq #(.W(QW), .DEPTH(DQ_DEPTH)) u_dq (
    .clk   (clk),
    .rst   (rst),
    .push  (dq_push),
    .din   (dq_din),
    .pop   (dq_pop),
    .dout  (dq_dout),
    .empty (dq_empty),
    .full  (dq_full)
  );

  assign desc_valid               = !dq_empty;
  assign {desc_status, desc_len}  = dq_dout;
  assign desc_class               = desc_status[ST_CLS+1:ST_CLS];

  always_comb begin
    rd_go    = rd_en && !dq_empty;
    last_now = (rd_cnt == desc_len - LW'(1));
    dq_pop   = rd_go && last_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr   <= '0;
      rd_cnt   <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      rd_last  <= rd_go && last_now;
      if (rd_go) begin
        rd_ptr <= rd_ptr + PW'(1);
        rd_cnt <= last_now ? '0 : rd_cnt + LW'(1);
      end
    end
  end
endmodule

// File: rtl/rx_frame_buf_chk.sv
module rx_frame_buf_chk #(
  parameter int DEPTH = 2048,
  parameter int PW    = 12,
  parameter int LW    = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          stat_valid,
  input logic [15:0]   stat_word,
  input logic          desc_valid,
  input logic [LW-1:0] desc_len,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] cm_ptr,
  input logic [PW-1:0] rd_ptr
);
  logic [PW-1:0] occ;
  assign occ = wr_ptr - rd_ptr;

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= PW'(DEPTH));

  // R6
  ovf_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_word[5]) |-> !stat_word[0]);

  // R3
  drop_keeps_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !stat_word[0]) |-> (cm_ptr == $past(cm_ptr)));

  // R2
  accept_shows_desc_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_word[0]) |-> desc_valid);

  // R8
  read_needs_desc_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && desc_valid));

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (desc_len != '0 && desc_len <= LW'(DEPTH)));
endmodule

bind rx_frame_buf rx_frame_buf_chk #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stat_valid (stat_valid),
  .stat_word  (stat_word),
  .desc_valid (desc_valid),
  .desc_len   (desc_len),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .wr_ptr     (wr_ptr),
  .cm_ptr     (cm_ptr),
  .rd_ptr     (rd_ptr)
);

// File: tb/sim_rx_frame_buf.sv
`timescale 1ns/1ps
module sim_rx_frame_buf;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = '0;
  logic rx_crc_bad = 0, rx_frag_err = 0, rx_len_err = 0, rx_addr_hit = 0;
  logic [LW-1:0] thr_a = 12'd64, thr_b = 12'd256, thr_c = 12'd1024;
  logic stat_valid;
  logic [15:0] stat_word;
  logic desc_valid;
  logic [LW-1:0] desc_len;
  logic [1:0] desc_class;
  logic [15:0] desc_status;
  logic rd_en = 1'b0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic rd_last;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_frame_buf u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_crc_bad(rx_crc_bad), .rx_frag_err(rx_frag_err),
    .rx_len_err(rx_len_err), .rx_addr_hit(rx_addr_hit),
    .thr_a(thr_a), .thr_b(thr_b), .thr_c(thr_c),
    .stat_valid(stat_valid), .stat_word(stat_word), .desc_valid(desc_valid),
    .desc_len(desc_len), .desc_class(desc_class), .desc_status(desc_status),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic beat(input bit sof, input bit eof, input int dat,
                      input bit crc, input bit frag, input bit lerr, input bit hit);
    @(negedge clk);
    rx_valid    = 1'b1;
    rx_sof      = sof;
    rx_eof      = eof;
    rx_data     = 8'(dat);
    rx_crc_bad  = eof & crc;
    rx_frag_err = eof & frag;
    rx_len_err  = eof & lerr;
    rx_addr_hit = eof & hit;
  endtask

  task automatic go_idle();
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    rx_crc_bad = 0; rx_frag_err = 0; rx_len_err = 0; rx_addr_hit = 0;
  endtask

  // drives a whole frame; returns status sampled one cycle after the last byte
  task automatic send_frame(input int n, input int seed, input bit crc, input bit frag,
                            input bit lerr, input bit hit, output logic [15:0] st);
    for (int i = 0; i < n; i++)
      beat(i == 0, i == n - 1, seed + i, crc, frag, lerr, hit);
    @(negedge clk);
    go_idle();
    chk(stat_valid === 1'b1, "R2 stat_valid after end of frame", int'(stat_valid), 1);
    st = stat_word;
  endtask

  task automatic read_frame(input int n, input int seed, input string tag);
    chk(desc_valid === 1'b1, {tag, " desc_valid"}, int'(desc_valid), 1);
    chk(int'(desc_len) == n, {tag, " desc_len"}, int'(desc_len), n);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk(rd_valid === 1'b1, {tag, " R9 rd_valid"}, int'(rd_valid), 1);
        chk(int'(rd_data) == ((seed + k - 1) & 255), {tag, " R9 rd_data"},
            int'(rd_data), (seed + k - 1) & 255);
        if (k == n || k == n - 1)
          chk(rd_last === (k == n), {tag, " R9 rd_last"}, int'(rd_last), int'(k == n));
      end
      rd_en = (k < n);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(desc_valid === 1'b0, "R1 desc_valid after reset", int'(desc_valid), 0);
    chk(stat_valid === 1'b0, "R1 stat_valid after reset", int'(stat_valid), 0);
    chk(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
  endtask

  task automatic t_good();
    logic [15:0] st;
    send_frame(60, 3, 0, 0, 0, 1, st);
    chk(st[0] === 1'b1, "R2 accepted bit", int'(st[0]), 1);
    chk(int'(st[5:1]) == 0, "R2 no error bits", int'(st[5:1]), 0);
    read_frame(60, 3, "R2 good frame");
    @(negedge clk);
    chk(desc_valid === 1'b0, "R9 descriptor removed after last byte", int'(desc_valid), 0);
  endtask

  task automatic t_errors();
    logic [15:0] st;
    send_frame(30, 7, 1, 0, 0, 1, st);
    chk(st[1:0] == 2'b10, "R3 crc status", int'(st), 2);
    chk(desc_valid === 1'b0, "R3 crc frame not visible", int'(desc_valid), 0);
    send_frame(25, 8, 0, 1, 0, 1, st);
    chk(st[0] == 0 && st[2] == 1, "R3 fragment status", int'(st), 4);
    chk(desc_valid === 1'b0, "R3 fragment frame not visible", int'(desc_valid), 0);
    send_frame(40, 9, 0, 0, 1, 1, st);
    chk(st[0] == 0 && st[3] == 1, "R3 length status", int'(st), 8);
    send_frame(35, 10, 0, 0, 0, 0, st);
    chk(st[0] == 0 && st[4] == 1, "R4 address miss status", int'(st), 16);
    chk(desc_valid === 1'b0, "R4 address miss not visible", int'(desc_valid), 0);
    send_frame(20, 100, 0, 0, 0, 1, st);
    chk(st[0] === 1'b1, "R3 good frame after drops accepted", int'(st[0]), 1);
    read_frame(20, 100, "R3 frame after drops");
  endtask

  task automatic t_class_one(input int n, input int exp_cls);
    logic [15:0] st;
    send_frame(n, n, 0, 0, 0, 1, st);
    chk(int'(st[7:6]) == exp_cls, "R5 status class", int'(st[7:6]), exp_cls);
    chk(int'(desc_class) == exp_cls, "R5 desc_class", int'(desc_class), exp_cls);
    read_frame(n, n, "R5 class frame");
  endtask

  task automatic t_class();
    t_class_one(64, 0);
    t_class_one(65, 1);
    t_class_one(256, 1);
    t_class_one(1024, 2);
    t_class_one(1025, 3);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 10; i++) beat(i == 0, 0, 40 + i, 0, 0, 0, 0);
    @(negedge clk);
    go_idle();
    chk(desc_valid === 1'b0, "R8 no descriptor mid-frame", int'(desc_valid), 0);
    chk(stat_valid === 1'b0, "R8 no status mid-frame", int'(stat_valid), 0);
    rd_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rd_valid === 1'b0, "R8 rd_en without descriptor", int'(rd_valid), 0);
    rd_en = 1'b0;
    for (int i = 10; i < 20; i++) beat(0, i == 19, 40 + i, 0, 0, 0, 1);
    @(negedge clk);
    go_idle();
    chk(stat_valid === 1'b1 && stat_word[0] === 1'b1, "R8 split frame committed",
        int'(stat_word), 1);
    read_frame(20, 40, "R8 split frame");
  endtask

  task automatic t_abort();
    logic [15:0] st;
    for (int i = 0; i < 3; i++) beat(0, i == 2, 200 + i, 0, 0, 0, 1);
    for (int i = 0; i < 30; i++) beat(i == 0, 0, 50 + i, 0, 0, 0, 0);
    @(negedge clk);
    go_idle();
    chk(stat_valid === 1'b0, "R7 stray bytes give no status", int'(stat_valid), 0);
    chk(desc_valid === 1'b0, "R7 stray bytes give no descriptor", int'(desc_valid), 0);
    send_frame(40, 90, 0, 0, 0, 1, st);
    chk(st[0] === 1'b1, "R7 restarted frame accepted", int'(st[0]), 1);
    read_frame(40, 90, "R7 restarted frame");
  endtask

  task automatic t_overflow();
    logic [15:0] st;
    send_frame(1500, 11, 0, 0, 0, 1, st);
    chk(st[0] === 1'b1, "R6 first large frame accepted", int'(st[0]), 1);
    send_frame(600, 60, 0, 0, 0, 1, st);
    chk(st[5] === 1'b1 && st[0] === 1'b0, "R6 overflow frame dropped", int'(st), 32);
    read_frame(1500, 11, "R6 earlier frame intact");
    send_frame(600, 61, 0, 0, 0, 1, st);
    chk(st[0] === 1'b1, "R6 frame fits after drain", int'(st[0]), 1);
    read_frame(600, 61, "R6 refill frame");
  endtask

  task automatic t_dqfull();
    logic [15:0] st;
    for (int f = 0; f < 8; f++) begin
      send_frame(10, 16 * f, 0, 0, 0, 1, st);
      chk(st[0] === 1'b1, "R10 queued frame accepted", int'(st[0]), 1);
    end
    send_frame(10, 250, 0, 0, 0, 1, st);
    chk(st[5] === 1'b1 && st[0] === 1'b0, "R10 queue-full frame dropped", int'(st), 32);
    for (int f = 0; f < 8; f++) read_frame(10, 16 * f, "R10 queued frame");
    @(negedge clk);
    chk(desc_valid === 1'b0, "R10 queue empty after drain", int'(desc_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_good();
    t_errors();
    t_class();
    t_hold();
    t_abort();
    t_overflow();
    t_dqfull();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule